// File: doc/BRIEF.md
# UART receive acceptance filter

This block sits after a UART deserializer and decides what happens to each received character. Each character arrives as a one-cycle valid pulse. The pulse carries the data word and the character's status: parity error, framing error, break, and address bit. The filter applies three independent policies. The first decides whether characters with errors are accepted. The second decides whether break characters are reported. The third is a dormant mode for multiprocessor links, in which only address-type characters wake the host.

An accepted character is written into the receive buffer. It raises the ready flag and latches its own status bits. The host clears the flag and the status bits with a one-cycle read acknowledge. The block finds idle lines on its own, by counting high bit periods between characters. An auto-baud variant of the dormant mode wakes only on a break followed by a synch character.

A hold input acts as the block's software reset, and the policy settings are sampled only while hold is asserted.

Top module: `uart_rx_gate`

## Requirements
- R1: While `cfg_hold` is 1, or `rst_n` is 0, the buffer, the ready flag, all status bits, the idle tracker and the pending-break state are cleared, and they read zero one cycle later.
- R2: The four policy inputs are captured only on cycles with `cfg_hold` = 1. Changing them while `cfg_hold` = 0 has no effect on how later characters are handled.
- R3: With dormant off, an error-free, non-break character is stored. In that case `rx_ready` and `rx_data` update on the clock edge that samples `chr_valid`.
- R4: A non-break character with a parity or framing error is discarded when error acceptance is 0. When error acceptance is 1, it is stored and `st_parity` and `st_frame` copy its error flags.
- R5: A break character is discarded when break reporting is 0. When break reporting is 1, it is stored with `st_break` = 1.
- R6: With dormant on and auto-baud off, a character is eligible only if its address bit is 1 or an idle line preceded it. `st_wake` records that condition for the stored character.
- R7: An idle line is seen after IDLE_BITS consecutive `bit_tick` pulses with `line_in` high, counted since the last character. A low sample restarts the count. The idle mark applies to the next character only.
- R8: With dormant and auto-baud both on, a break sets no flag. The character right after a break wakes the block only if it equals the synch code (alternating 01 pattern, 0x55 for 8 bits) and has no error.
- R9: Storing a character while `rx_ready` is already 1, with no read on that cycle, sets `st_overrun`. The new character overwrites the buffer.
- R10: `rd_ack` clears `rx_ready` and all status bits but keeps `rx_data`. If a store occurs on the same cycle, the store wins and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_hold | input | 1 | Software reset; policy inputs sampled while high |
| cfg_err_accept | input | 1 | Accept characters with parity/framing errors |
| cfg_brk_report | input | 1 | Report break characters |
| cfg_dormant | input | 1 | Address-only wakeup mode |
| cfg_autobaud | input | 1 | Break-plus-synch wakeup in dormant mode |
| bit_tick | input | 1 | One pulse per bit period for idle detection |
| line_in | input | 1 | Receive line level sampled at bit_tick |
| chr_valid | input | 1 | Character-complete pulse from deserializer |
| chr_data | input | DATA_W | Received data word |
| chr_parity_err | input | 1 | Parity error of this character |
| chr_frame_err | input | 1 | Framing error of this character |
| chr_break | input | 1 | Character is a break |
| chr_addr | input | 1 | Address bit of this character |
| rd_ack | input | 1 | Host read of the buffer |
| rx_data | output | DATA_W | Receive buffer |
| rx_ready | output | 1 | Receive-ready flag |
| st_parity | output | 1 | Stored character had a parity error |
| st_frame | output | 1 | Stored character had a framing error |
| st_break | output | 1 | Stored character was a break |
| st_overrun | output | 1 | A store happened over an unread character |
| st_wake | output | 1 | Stored character had the address bit set or followed an idle line |

## Verification
The hardest state to reach from the ports is an armed idle mark that coincides with dormant mode. Getting there needs an unbroken run of exactly IDLE_BITS high bit samples after the last character. Random tick and line patterns rarely produce that run just before a character.

Directed sequences therefore feed nine high ticks, then ten, and then a run broken by one low sample, each followed by a character. A second hard case is the break-then-synch wakeup, which is driven explicitly. Random phases sweep all sixteen policy combinations against a bench-side model. They also toggle the policy inputs while hold is low, to show those changes are ignored.

// File: rtl/uart_rx_gate.sv
module uart_rx_gate #(
  parameter int DATA_W    = 8,
  parameter int IDLE_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hold,
  input  logic              cfg_err_accept,
  input  logic              cfg_brk_report,
  input  logic              cfg_dormant,
  input  logic              cfg_autobaud,
  input  logic              bit_tick,
  input  logic              line_in,
  input  logic              chr_valid,
  input  logic [DATA_W-1:0] chr_data,
  input  logic              chr_parity_err,
  input  logic              chr_frame_err,
  input  logic              chr_break,
  input  logic              chr_addr,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              st_parity,
  output logic              st_frame,
  output logic              st_break,
  output logic              st_overrun,
  output logic              st_wake
);
  localparam int CNT_W = $clog2(IDLE_BITS + 1);
  localparam logic [DATA_W-1:0] SYNC_CODE = {(DATA_W/2){2'b01}};
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(IDLE_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_BITS - 1);

  logic acc_q, brkrep_q, dorm_q, abaud_q;
  logic [CNT_W-1:0] idle_cnt;
  logic idle_armed, brk_pend;

  wire chr_err   = chr_parity_err | chr_frame_err;
  wire sync_hit  = brk_pend & (chr_data == SYNC_CODE) & ~chr_err & ~chr_break;
  wire wake_ok   = ~dorm_q | (abaud_q ? sync_hit : (chr_addr | idle_armed));
  wire policy_ok = chr_break ? brkrep_q : (~chr_err | acc_q);
  wire store     = chr_valid & wake_ok & policy_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= 1'b0;
      brkrep_q <= 1'b0;
      dorm_q   <= 1'b0;
      abaud_q  <= 1'b0;
    end else if (cfg_hold) begin
      acc_q    <= cfg_err_accept;
      brkrep_q <= cfg_brk_report;
      dorm_q   <= cfg_dormant;
      abaud_q  <= cfg_autobaud;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt   <= '0;
      idle_armed <= 1'b0;
      brk_pend   <= 1'b0;
    end else if (cfg_hold) begin
      idle_cnt   <= '0;
      idle_armed <= 1'b0;
      brk_pend   <= 1'b0;
    end else if (chr_valid) begin
      idle_cnt   <= '0;
      idle_armed <= 1'b0;
      brk_pend   <= dorm_q & abaud_q & chr_break;
    end else if (bit_tick) begin
      if (line_in) begin
        if (idle_cnt != CNT_MAX) idle_cnt <= idle_cnt + 1'b1;
        if (idle_cnt == CNT_LAST) idle_armed <= 1'b1;
      end else begin
        idle_cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_ready   <= 1'b0;
      st_parity  <= 1'b0;
      st_frame   <= 1'b0;
      st_break   <= 1'b0;
      st_overrun <= 1'b0;
      st_wake    <= 1'b0;
    end else if (cfg_hold) begin
      rx_data    <= '0;
      rx_ready   <= 1'b0;
      st_parity  <= 1'b0;
      st_frame   <= 1'b0;
      st_break   <= 1'b0;
      st_overrun <= 1'b0;
      st_wake    <= 1'b0;
    end else if (store) begin
      rx_data    <= chr_data;
      rx_ready   <= 1'b1;
      st_parity  <= chr_parity_err;
      st_frame   <= chr_frame_err;
      st_break   <= chr_break;
      st_overrun <= (rx_ready | st_overrun) & ~rd_ack;
      st_wake    <= chr_addr | idle_armed;
    end else if (rd_ack) begin
      rx_ready   <= 1'b0;
      st_parity  <= 1'b0;
      st_frame   <= 1'b0;
      st_break   <= 1'b0;
      st_overrun <= 1'b0;
      st_wake    <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_gate_chk.sv
module uart_rx_gate_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_hold,
  input logic              chr_valid,
  input logic              chr_parity_err,
  input logic              chr_frame_err,
  input logic              chr_break,
  input logic              rd_ack,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ready,
  input logic              st_overrun,
  input logic              acc_q,
  input logic              brkrep_q
);
  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hold |=> (!rx_ready && !st_overrun && rx_data == '0)); // R1
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(chr_valid)); // R3
  AST_ERR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_valid && !cfg_hold && !acc_q && (chr_parity_err || chr_frame_err) && !chr_break && !rx_ready)
      |=> !rx_ready); // R4
  AST_BRK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_valid && !cfg_hold && !brkrep_q && chr_break && !rx_ready) |=> !rx_ready); // R5
  AST_OVR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_overrun) |-> $past(rx_ready)); // R9
  AST_BUF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> ($past(chr_valid) || $past(cfg_hold))); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !chr_valid && !cfg_hold) |=> (!rx_ready && !st_overrun)); // R10
endmodule

bind uart_rx_gate uart_rx_gate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .chr_valid(chr_valid),
  .chr_parity_err(chr_parity_err), .chr_frame_err(chr_frame_err),
  .chr_break(chr_break), .rd_ack(rd_ack), .rx_data(rx_data),
  .rx_ready(rx_ready), .st_overrun(st_overrun), .acc_q(acc_q),
  .brkrep_q(brkrep_q)
);

// File: tb/uart_rx_gate_bench.sv
module uart_rx_gate_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, cfg_hold = 1'b0;
  logic cfg_err_accept = 0, cfg_brk_report = 0, cfg_dormant = 0, cfg_autobaud = 0;
  logic bit_tick = 0, line_in = 1, chr_valid = 0, rd_ack = 0;
  logic [7:0] chr_data = '0;
  logic chr_parity_err = 0, chr_frame_err = 0, chr_break = 0, chr_addr = 0;
  logic [7:0] rx_data;
  logic rx_ready, st_parity, st_frame, st_break, st_overrun, st_wake;

  uart_rx_gate #(.DATA_W(8), .IDLE_BITS(10)) u_uart_rx_gate (.*);

  int checks = 0, failures = 0;
  bit m_acc, m_brk, m_dorm, m_ab, m_pend, m_armed;
  int m_cnt;
  bit m_flag, m_par, m_frm, m_bk, m_ovr, m_wake;
  bit [7:0] m_buf;

  task automatic check(input logic [13:0] act, input logic [13:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    bit err, wake, ok, st;
    if (cfg_hold) begin
      {m_acc, m_brk, m_dorm, m_ab} = {cfg_err_accept, cfg_brk_report, cfg_dormant, cfg_autobaud};
      {m_pend, m_armed, m_flag, m_par, m_frm, m_bk, m_ovr, m_wake} = '0;
      m_cnt = 0; m_buf = '0;
      return;
    end
    err  = chr_parity_err | chr_frame_err;
    wake = !m_dorm || (m_ab ? (m_pend && chr_data == 8'h55 && !err && !chr_break)
                            : (chr_addr || m_armed));
    ok   = chr_break ? m_brk : (!err || m_acc);
    st   = chr_valid && wake && ok;
    if (st) begin
      m_ovr = (m_flag || m_ovr) && !rd_ack;
      m_buf = chr_data; m_flag = 1;
      m_par = chr_parity_err; m_frm = chr_frame_err; m_bk = chr_break;
      m_wake = chr_addr || m_armed;
    end else if (rd_ack) begin
      {m_flag, m_par, m_frm, m_bk, m_ovr, m_wake} = '0;
    end
    if (chr_valid) begin
      m_pend = m_dorm && m_ab && chr_break; m_cnt = 0; m_armed = 0;
    end else if (bit_tick) begin
      if (line_in) begin
        if (m_cnt == 9) m_armed = 1;
        if (m_cnt < 10) m_cnt++;
      end else m_cnt = 0;
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    check({rx_ready, st_parity, st_frame, st_break, st_overrun, st_wake, rx_data},
          {m_flag, m_par, m_frm, m_bk, m_ovr, m_wake, m_buf}, tag);
    chr_valid = 0; rd_ack = 0; bit_tick = 0; cfg_hold = 0;
    {chr_parity_err, chr_frame_err, chr_break, chr_addr} = '0;
  endtask

  task automatic configure(input bit acc, input bit brk, input bit dm, input bit ab);
    {cfg_err_accept, cfg_brk_report, cfg_dormant, cfg_autobaud} = {acc, brk, dm, ab};
    cfg_hold = 1;
    step("R1 hold");
  endtask

  task automatic send(input logic [7:0] d, input bit pe, input bit fe, input bit bk,
                      input bit ad, input bit rd, input string tag);
    chr_valid = 1; chr_data = d;
    {chr_parity_err, chr_frame_err, chr_break, chr_addr} = {pe, fe, bk, ad};
    rd_ack = rd;
    step(tag);
  endtask

  task automatic ticks(input int n, input bit lvl);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; line_in = lvl; step("R7 tick");
    end
    line_in = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check({rx_ready, st_overrun, rx_data}, '0, "R1 reset");
    rst_n = 1;
    configure(0, 0, 0, 0);

    send(8'hA5, 0, 0, 0, 0, 0, "R3 plain store");
    check({rx_ready, rx_data}, {1'b1, 8'hA5}, "R3 flag and data");
    send(8'h11, 0, 0, 0, 0, 1, "R10 store with read");
    check({rx_ready, st_overrun, rx_data}, {2'b10, 8'h11}, "R10 store wins");
    send(8'h22, 0, 0, 0, 0, 0, "R9 overrun");
    check({rx_ready, st_overrun, rx_data}, {2'b11, 8'h22}, "R9 overrun overwrite");
    rd_ack = 1; step("R10 read");
    check({rx_ready, st_overrun, rx_data}, {2'b00, 8'h22}, "R10 read keeps data");

    cfg_err_accept = 1;
    send(8'h33, 1, 0, 0, 0, 0, "R2 live change ignored");
    check(rx_ready, 0, "R2 error still dropped");
    send(8'h44, 0, 0, 1, 0, 0, "R5 break dropped");
    check(rx_ready, 0, "R5 break dropped");

    configure(1, 1, 0, 0);
    send(8'h55, 1, 1, 0, 0, 0, "R4 error accepted");
    check({rx_ready, st_parity, st_frame}, 3'b111, "R4 error bits");
    send(8'h00, 0, 1, 1, 0, 1, "R5 break reported");
    check({rx_ready, st_break}, 2'b11, "R5 break bit");

    configure(0, 0, 1, 0);
    send(8'h01, 0, 0, 0, 0, 0, "R6 dormant drop");
    check(rx_ready, 0, "R6 dormant drop");
    send(8'h02, 0, 0, 0, 1, 0, "R6 address wake");
    check({rx_ready, st_wake}, 2'b11, "R6 address wake");
    rd_ack = 1; step("R10 read");
    ticks(9, 1);
    send(8'h03, 0, 0, 0, 0, 0, "R7 nine ticks");
    check(rx_ready, 0, "R7 nine ticks not idle");
    ticks(5, 1); ticks(1, 0); ticks(5, 1);
    send(8'h04, 0, 0, 0, 0, 0, "R7 broken run");
    check(rx_ready, 0, "R7 broken run not idle");
    ticks(10, 1);
    send(8'h05, 0, 0, 0, 0, 0, "R7 idle wake");
    check({rx_ready, st_wake, rx_data}, {2'b11, 8'h05}, "R7 idle wake");
    rd_ack = 1; step("R10 read");
    send(8'h06, 0, 0, 0, 0, 0, "R7 mark consumed");
    check(rx_ready, 0, "R7 mark consumed");

    configure(0, 1, 1, 1);
    send(8'h00, 0, 0, 1, 0, 0, "R8 break alone");
    check(rx_ready, 0, "R8 break alone");
    send(8'h55, 0, 0, 0, 0, 0, "R8 synch wake");
    check({rx_ready, rx_data}, {1'b1, 8'h55}, "R8 synch wake");
    rd_ack = 1; step("R10 read");
    send(8'h55, 0, 0, 0, 0, 0, "R8 synch without break");
    check(rx_ready, 0, "R8 synch without break");

    for (int p = 0; p < 32; p++) begin
      configure(p[0], p[1], p[2], p[3]);
      for (int s = 0; s < 300; s++) begin
        chr_valid = ($urandom % 100) < 30;
        chr_data = ($urandom % 5 == 0) ? 8'h55 : 8'($urandom);
        chr_parity_err = ($urandom % 100) < 15;
        chr_frame_err = ($urandom % 100) < 15;
        chr_break = ($urandom % 100) < 10;
        chr_addr = ($urandom % 100) < 25;
        bit_tick = ($urandom % 100) < 70;
        line_in = ($urandom % 100) < 95;
        rd_ack = ($urandom % 100) < 20;
        if ($urandom % 50 == 0) cfg_err_accept = ~cfg_err_accept;
        if ($urandom % 50 == 0) cfg_dormant = ~cfg_dormant;
        step("R2 R3 R4 R5 R6 R8 R9 R10 random");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule